// File: doc/BRIEF.md
# Video Preamplifier Control Register Slave (I2C, write-only)

This block is the control-register front end of an analog RGB video preamplifier. It listens on a two-wire I2C bus as a receive-only slave, sampling SCL and SDA with a fast system clock. It answers one fixed 7-bit device address. After the address it takes one sub-address byte and then any number of data bytes. Each data byte lands in an 8-bit shadow register, and the sub-address then steps forward by one.

The shadow registers drive gain, black-level, cutoff, detector and sharpness settings, and several registers pack more than one field. The only thing the slave does on SDA is pull it low during acknowledge bits, as an open-drain output. A `busy` flag covers each transfer so that a later stage can tell when the shadow contents are settled before it commits them at vertical blank.

The controller is one state machine. Its states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_SUB`, `ST_SUB_ACK`, `ST_DATA`, `ST_DATA_ACK` and `ST_IGNORE`, and its transitions are:
- A START moves any state to `ST_ADDR`.
- A STOP moves any state to `ST_IDLE`.
- When an address byte matches, `ST_ADDR` moves to `ST_ADDR_ACK`. On a mismatch or a read request it moves to `ST_IGNORE`.
- After eight bits, `ST_SUB` moves to `ST_SUB_ACK` and `ST_DATA` moves to `ST_DATA_ACK`.
- On the SCL fall that ends an acknowledge bit, each ACK state moves to the next receive state: `ST_ADDR_ACK` to `ST_SUB`, `ST_SUB_ACK` to `ST_DATA`, and `ST_DATA_ACK` back to `ST_DATA`.

Top module: `vidctl_i2c_regs`

## Requirements
- R1: After reset every field output is 0, `busy` is 0 and `sda_drive_low` is 0.
- R2: An address byte of 0x40 (7-bit address 0x20, R/W bit 0) is acknowledged. Every other 7-bit address, and the read byte 0x41, is not acknowledged. After such a NACK, no further byte is acknowledged and no register is written until the next START.
- R3: The first byte after an accepted address is the sub-address and is acknowledged. Each following byte is acknowledged, written to the register at the current sub-address, and then the sub-address increases by one.
- R4: Sub-addresses 0x00 to 0x0A store data. A data byte sent to a higher sub-address is acknowledged but changes nothing. The sub-address stops at 0xFF and never wraps back to 0x00.
- R5: The fields map to register bits as follows:
  - 0x00 is `contrast`.
  - 0x01 holds `blank_mode` in bit 6 and `brightness` in bits 5:0.
  - 0x02, 0x03, 0x04 and 0x06 are `cutoff_r`, `cutoff_g`, `cutoff_b` and `cutoff_all`.
  - 0x05 holds `slice_lvl` in bits 7:6 and `osd_gain` in bits 5:0.
  - 0x07, 0x08 and 0x09 are `subcon_r`, `subcon_g` and `subcon_b`.
  - 0x0A holds `detect_off` in bit 7, `sharp_off` in bit 6, `sync_off` in bit 5, `sharp_tc` in bit 4 and `sharp_gain` in bits 3:0.
- R6: SDA falling while SCL is high is a START. At any point, including mid-transfer as a repeated START, it restarts the address phase.
- R7: SDA rising while SCL is high is a STOP. It ends the transfer, and `busy` reads 0 afterwards.
- R8: `busy` rises only after a START. It stays high until a STOP, or until the address is not acknowledged.
- R9: `sda_drive_low` is asserted only inside an acknowledge bit of a transfer. It changes level only while the synchronized SCL is low.
- R10: Shadow registers change only during a transfer in which `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| busy | output | 1 | Transfer in progress |
| contrast | output | 8 | Common contrast |
| blank_mode | output | 1 | Blanking level select |
| brightness | output | 6 | Black level |
| cutoff_r | output | 8 | Red cutoff |
| cutoff_g | output | 8 | Green cutoff |
| cutoff_b | output | 8 | Blue cutoff |
| cutoff_all | output | 8 | Common cutoff |
| slice_lvl | output | 2 | Video detect slice level |
| osd_gain | output | 6 | On-screen display gain |
| subcon_r | output | 8 | Red sub-contrast |
| subcon_g | output | 8 | Green sub-contrast |
| subcon_b | output | 8 | Blue sub-contrast |
| detect_off | output | 1 | Video detect output disable |
| sharp_off | output | 1 | Sharpness disable |
| sync_off | output | 1 | Sync output disable |
| sharp_tc | output | 1 | Sharpness time-constant select |
| sharp_gain | output | 4 | Sharpness gain |

## Verification
The assertions assume that SCL stays low for several system clocks after each falling edge. This lets the acknowledge driver move while the synchronized clock is still low. They also assume that SDA only changes away from SCL edges, except at deliberate START and STOP conditions, so that no spurious START or STOP appears. The bench drives the bus with a master whose quarter bit period is five system clocks, with SCL low for ten clocks. It changes SDA only at the middle of the low phase, or during the high phase when it means to send START or STOP. It models the open-drain line as the AND of the master's level and the slave's release.

// File: rtl/vci_pkg.sv
package vci_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 11;
    localparam int SUB_W    = 8;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_t;
endpackage

// File: rtl/vci_sync_edge.sv
module vci_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/vci_ctrl_fsm.sv
module vci_ctrl_fsm
    import vci_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_drive_low,
    output logic              busy,
    output logic              wr_en,
    output logic [SUB_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    bus_state_t        state, state_nx;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [SUB_W-1:0]  subaddr;
    logic              byte_done;
    logic              receiving;
    logic              addr_hit;

    assign byte_done = scl_fall && (bitcnt == CNT_W'(BYTE_W));
    assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign addr_hit  = (shreg == {DEV_ADDR, 1'b0});

    // next-state decision
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                ST_ADDR:     if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_SUB:      if (byte_done) state_nx = ST_SUB_ACK;
                ST_DATA:     if (byte_done) state_nx = ST_DATA_ACK;
                ST_ADDR_ACK: if (scl_fall)  state_nx = ST_SUB;
                ST_SUB_ACK:  if (scl_fall)  state_nx = ST_DATA;
                ST_DATA_ACK: if (scl_fall)  state_nx = ST_DATA;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // byte shifter, bit counter and sub-address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bitcnt  <= '0;
            subaddr <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt <= '0;
            end else if (receiving && scl_rise && bitcnt != CNT_W'(BYTE_W)) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end else if (!receiving && scl_fall) begin
                bitcnt <= '0;
            end
            if (!start_det && !stop_det && byte_done) begin
                if (state == ST_SUB) begin
                    subaddr <= shreg;
                end else if (state == ST_DATA) begin
                    wr_en   <= (subaddr < SUB_W'(NUM_REGS));
                    wr_addr <= subaddr;
                    wr_data <= shreg;
                    if (subaddr != '1) subaddr <= subaddr + 1'b1;
                end
            end
        end
    end

    // registered outputs from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drive_low <= 1'b0;
            busy          <= 1'b0;
        end else begin
            sda_drive_low <= (state_nx == ST_ADDR_ACK) || (state_nx == ST_SUB_ACK) ||
                             (state_nx == ST_DATA_ACK);
            busy          <= (state_nx != ST_IDLE) && (state_nx != ST_IGNORE);
        end
    end
endmodule

// File: rtl/vci_regbank.sv
module vci_regbank
    import vci_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SUB_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_flat[i*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && wr_addr == SUB_W'(i))
                regs_flat[i*BYTE_W +: BYTE_W] <= wr_data;
        end
    end
endmodule

// File: rtl/vidctl_i2c_regs.sv
module vidctl_i2c_regs
    import vci_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    output logic       busy,
    output logic [7:0] contrast,
    output logic       blank_mode,
    output logic [5:0] brightness,
    output logic [7:0] cutoff_r,
    output logic [7:0] cutoff_g,
    output logic [7:0] cutoff_b,
    output logic [7:0] cutoff_all,
    output logic [1:0] slice_lvl,
    output logic [5:0] osd_gain,
    output logic [7:0] subcon_r,
    output logic [7:0] subcon_g,
    output logic [7:0] subcon_b,
    output logic       detect_off,
    output logic       sharp_off,
    output logic       sync_off,
    output logic       sharp_tc,
    output logic [3:0] sharp_gain
);
    logic                       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                       wr_en;
    logic [SUB_W-1:0]           wr_addr;
    logic [BYTE_W-1:0]          wr_data;
    logic [NUM_REGS*BYTE_W-1:0] regs_flat;
    logic                       reg1_bit7_unused;

    vci_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    vci_ctrl_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_drive_low(sda_drive_low), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    vci_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    assign contrast         = regs_flat[0*8 +: 8];
    assign reg1_bit7_unused = regs_flat[1*8 + 7];
    assign blank_mode       = regs_flat[1*8 + 6];
    assign brightness       = regs_flat[1*8 +: 6];
    assign cutoff_r         = regs_flat[2*8 +: 8];
    assign cutoff_g         = regs_flat[3*8 +: 8];
    assign cutoff_b         = regs_flat[4*8 +: 8];
    assign slice_lvl        = regs_flat[5*8 + 6 +: 2];
    assign osd_gain         = regs_flat[5*8 +: 6];
    assign cutoff_all       = regs_flat[6*8 +: 8];
    assign subcon_r         = regs_flat[7*8 +: 8];
    assign subcon_g         = regs_flat[8*8 +: 8];
    assign subcon_b         = regs_flat[9*8 +: 8];
    assign detect_off       = regs_flat[10*8 + 7];
    assign sharp_off        = regs_flat[10*8 + 6];
    assign sync_off         = regs_flat[10*8 + 5];
    assign sharp_tc         = regs_flat[10*8 + 4];
    assign sharp_gain       = regs_flat[10*8 +: 4];
endmodule

// File: rtl/vidctl_i2c_regs_chk.sv
module vidctl_i2c_regs_chk
    import vci_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_s,
    input logic                       start_det,
    input logic                       stop_det,
    input logic                       busy,
    input logic                       sda_drive_low,
    input logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    assert_ack_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_s);

    assert_ack_inside_transfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> busy);

    assert_busy_rises_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_det));

    assert_stop_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !busy);

    assert_regs_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(regs_flat));
endmodule

bind vidctl_i2c_regs vidctl_i2c_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .busy(busy), .sda_drive_low(sda_drive_low),
    .regs_flat(regs_flat)
);

// File: tb/vidctl_i2c_regs_test.sv
`timescale 1ns/1ps
module vidctl_i2c_regs_test;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_drive_low, busy;
    logic [7:0] contrast, cutoff_r, cutoff_g, cutoff_b, cutoff_all, subcon_r, subcon_g, subcon_b;
    logic blank_mode, detect_off, sharp_off, sync_off, sharp_tc;
    logic [5:0] brightness, osd_gain;
    logic [1:0] slice_lvl;
    logic [3:0] sharp_gain;

    int errors = 0;
    int checks = 0;
    logic [7:0] expv [0:10];
    logic ack;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    vidctl_i2c_regs uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low), .busy(busy),
        .contrast(contrast), .blank_mode(blank_mode), .brightness(brightness),
        .cutoff_r(cutoff_r), .cutoff_g(cutoff_g), .cutoff_b(cutoff_b),
        .cutoff_all(cutoff_all), .slice_lvl(slice_lvl), .osd_gain(osd_gain),
        .subcon_r(subcon_r), .subcon_g(subcon_g), .subcon_b(subcon_b),
        .detect_off(detect_off), .sharp_off(sharp_off), .sync_off(sync_off),
        .sharp_tc(sharp_tc), .sharp_gain(sharp_gain)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((k * 37 + seed * 91 + 5) ^ (seed << 3));
    endfunction

    task automatic check_fields(input string req);
        check(req, "contrast",   contrast,   expv[0]);
        check(req, "blank_mode", blank_mode, expv[1][6]);
        check(req, "brightness", brightness, expv[1][5:0]);
        check(req, "cutoff_r",   cutoff_r,   expv[2]);
        check(req, "cutoff_g",   cutoff_g,   expv[3]);
        check(req, "cutoff_b",   cutoff_b,   expv[4]);
        check(req, "slice_lvl",  slice_lvl,  expv[5][7:6]);
        check(req, "osd_gain",   osd_gain,   expv[5][5:0]);
        check(req, "cutoff_all", cutoff_all, expv[6]);
        check(req, "subcon_r",   subcon_r,   expv[7]);
        check(req, "subcon_g",   subcon_g,   expv[8]);
        check(req, "subcon_b",   subcon_b,   expv[9]);
        check(req, "detect_off", detect_off, expv[10][7]);
        check(req, "sharp_off",  sharp_off,  expv[10][6]);
        check(req, "sync_off",   sync_off,   expv[10][5]);
        check(req, "sharp_tc",   sharp_tc,   expv[10][4]);
        check(req, "sharp_gain", sharp_gain, expv[10][3:0]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(2 * Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        acked = ~sda_line;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    // sub-address then n bytes; expected pointer saturates at 0xFF
    task automatic write_burst(input logic [7:0] sub, input int n, input int seed,
                               input string req);
        int ptr;
        bus_start();
        send_byte(8'h40, ack);
        check("R2", "address 0x40 acked", ack, 1'b1);
        check("R8", "busy during transfer", busy, 1'b1);
        send_byte(sub, ack);
        check("R3", "sub-address acked", ack, 1'b1);
        ptr = sub;
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed, k), ack);
            check(req, "data byte acked", ack, 1'b1);
            if (ptr <= 10) expv[ptr] = pat(seed, k);
            if (ptr < 255) ptr++;
        end
        bus_stop();
        check("R7", "busy after stop", busy, 1'b0);
        check("R9", "no drive after stop", sda_drive_low, 1'b0);
        check_fields(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i <= 10; i++) expv[i] = 8'h00;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        check("R1", "busy at reset", busy, 1'b0);
        check("R1", "drive at reset", sda_drive_low, 1'b0);
        check_fields("R1");

        // R3 R5 full bursts with several patterns
        for (int s = 0; s < 4; s++) write_burst(8'h00, 11, s, "R5");

        // R4 single writes over sub-addresses 0x00..0x0F
        for (int a = 0; a < 16; a++) write_burst(8'(a), 1, 7 + a, "R4");

        // R4 burst crossing the end of the map
        write_burst(8'h09, 4, 20, "R4");
        // R4 pointer saturates at 0xFF and never wraps to 0x00
        write_burst(8'hF0, 20, 21, "R4");

        // R2 address sweep with write bit
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            check("R2", "address sweep ack", ack, (a == 32'h20));
            bus_stop();
        end
        // R2 read request rejected
        bus_start();
        send_byte(8'h41, ack);
        check("R2", "read byte nacked", ack, 1'b0);
        check("R8", "busy dropped after nack", busy, 1'b0);
        bus_stop();

        // R2 bytes after a NACK are ignored
        bus_start();
        send_byte(8'h42, ack);
        check("R2", "wrong address nacked", ack, 1'b0);
        send_byte(8'h00, ack);
        check("R2", "ignored byte not acked", ack, 1'b0);
        send_byte(8'h5A, ack);
        check("R2", "ignored data not acked", ack, 1'b0);
        check("R8", "busy low while ignoring", busy, 1'b0);
        bus_stop();
        check_fields("R2");

        // R6 repeated start mid-transfer
        bus_start();
        send_byte(8'h40, ack);
        send_byte(8'h02, ack);
        send_byte(8'h11, ack);
        expv[2] = 8'h11;
        bus_start();
        check("R6", "busy across repeated start", busy, 1'b1);
        send_byte(8'h40, ack);
        check("R6", "address after repeated start", ack, 1'b1);
        send_byte(8'h07, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        expv[7] = 8'h22;
        expv[8] = 8'h33;
        bus_stop();
        check_fields("R6");

        // R6 repeated start to a foreign address aborts, registers kept
        bus_start();
        send_byte(8'h40, ack);
        send_byte(8'h00, ack);
        bus_start();
        send_byte(8'hA0, ack);
        check("R6", "foreign address after restart", ack, 1'b0);
        send_byte(8'hFF, ack);
        check("R6", "data after foreign restart", ack, 1'b0);
        bus_stop();
        check_fields("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule